// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time calendar core. It counts seconds, minutes, hours, day of month, month, a two-byte year (low and high century bytes) and a weekday, all in BCD. Time advances once per second. A prescaler derives that second from a 32.768 kHz enable input. The core sits behind a simple word-indexed register bus: write strobes go in, and read data comes out combinationally from the addressed register.

Software starts and stops the clock through a run bit in the control register. It then polls the running flag in the status register, which follows the request after a short synchronisation delay. Time fields can be loaded only while the status flag shows the clock has stopped. A capture strobe freezes a copy of the live time, and a read-select bit makes time reads return that copy, so all eight fields can be read as one consistent set.

A seven-field alarm compares against the time at each second boundary and sets a sticky pending flag. Software clears the flag by writing one to it. The interrupt output is the pending flag gated by an enable bit.

Top module: `bcd_rtc`

## Requirements
- R1: After reset every time field reads 00, except day and month, which read 01. The alarm fields, control, status and interrupt-enable registers read 00, and `irq` is low.
- R2: Word index 0..7 holds time (seconds, minutes, hours, day, month, year-low, year-high, weekday). Index 8..14 holds the alarm in the same order without weekday. Index 15 is control, 16 is status and 17 is interrupt enable. Any other index reads 00. Written values are masked to 7, 7, 6, 6, 5, 8, 8 and 3 bits per field, and interrupt enable keeps only bit 7.
- R3: Control bit 0 requests run. Status bit 0 takes the requested value on the second `tick_32k` enable after the request is written, and it changes on no other cycle.
- R4: While status bit 0 is set, seconds advance exactly once per TICKS_PER_SEC enables. The prescaler is cleared while the clock is stopped.
- R5: Writes to time indices 0..7 are ignored while status bit 0 is set, including during the interval after a stop request but before the stop is confirmed.
- R6: Seconds and minutes roll from 59 to 00, and hours roll from 23 to 00, each carrying into the next field.
- R7: The day rolls to 01 after the last day of the month. April, June, September and November have 30 days, and February has 29 days in a leap year and 28 otherwise. A year is leap when year-high×100 + year-low is divisible by 4 and, if it is a century, also by 400. Month 12 rolls to 01 and carries into year-low, and year-low 99 rolls to 00 and carries into year-high.
- R8: The weekday (0..6) increments modulo 7 at every midnight.
- R9: Writing control bit 6 copies the live time into a snapshot. While control bit 7 is set, time reads return the snapshot. Control bit 6 reads back as 0.
- R10: Status bit 4 (alarm pending) is set when the time reached at a second boundary equals all seven alarm fields. Loading a matching time does not set it.
- R11: Writing 1 to status bit 4 clears it, and writing 0 to it has no effect. If an alarm match and a clear fall in the same cycle, the flag stays set.
- R12: `irq` is high exactly when status bit 4 is set and interrupt-enable bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the indexed register |
| irq | output | 1 | Alarm interrupt request |

## Verification
Two functions can meet in one cycle: an alarm match at a second boundary, and a software write that clears the pending flag. The bench first loads a time one second before the alarm and leaves the flag pending. It then issues the clearing write on the same enable pulse that completes the second, and expects status bit 4 to remain set afterwards. A plain clear on a later cycle must then drop the flag. The bench also writes a seconds value after a stop request but before the stop is confirmed, and expects that write to be refused.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [4:0] A_ALM  = 5'd8;
  localparam logic [4:0] A_ALMH = 5'd14;
  localparam logic [4:0] A_CTRL = 5'd15;
  localparam logic [4:0] A_STAT = 5'd16;
  localparam logic [4:0] A_IEN  = 5'd17;
  localparam logic [4:0] A_WDAY = 5'd7;

  logic [7:0] tm [8];
  logic [7:0] sh [8];
  logic [7:0] al [7];
  logic [7:0] nt [8];
  logic [PW-1:0] presc;
  logic ctrl_run, rdsel, run_s1, running, pend, int_en;
  logic sec_pulse, hit, leap;
  logic c_s, c_m, c_h, c_d, c_mo, c_yl;
  logic [7:0] dim;

  function automatic logic [7:0] fmask(input logic [2:0] i);
    case (i)
      3'd0, 3'd1: fmask = 8'h7F;
      3'd2, 3'd3: fmask = 8'h3F;
      3'd4:       fmask = 8'h1F;
      3'd7:       fmask = 8'h07;
      default:    fmask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] binc(input logic [7:0] v);
    binc = (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
  endfunction

  function automatic logic div4(input logic [7:0] v);
    logic [1:0] s;
    s = {v[4], 1'b0} + v[1:0];
    div4 = (s == 2'b00);
  endfunction

  wire wr_time = wr_en && (addr < A_ALM) && !running;
  wire wr_alm  = wr_en && (addr >= A_ALM) && (addr <= A_ALMH);
  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire clr_req = wr_en && (addr == A_STAT) && wdata[4];

  assign sec_pulse = running && tick_32k && (presc == LAST);
  assign leap = (tm[5] == 8'h00) ? div4(tm[6]) : div4(tm[5]);
  assign irq  = pend && int_en;

  always_comb begin
    case (tm[4])
      8'h02:                      dim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
    c_s  = (tm[0] == 8'h59);
    c_m  = c_s && (tm[1] == 8'h59);
    c_h  = c_m && (tm[2] == 8'h23);
    c_d  = c_h && (tm[3] == dim);
    c_mo = c_d && (tm[4] == 8'h12);
    c_yl = c_mo && (tm[5] == 8'h99);
    nt[0] = c_s ? 8'h00 : binc(tm[0]);
    nt[1] = c_s ? (c_m ? 8'h00 : binc(tm[1])) : tm[1];
    nt[2] = c_m ? (c_h ? 8'h00 : binc(tm[2])) : tm[2];
    nt[3] = c_h ? (c_d ? 8'h01 : binc(tm[3])) : tm[3];
    nt[4] = c_d ? (c_mo ? 8'h01 : binc(tm[4])) : tm[4];
    nt[5] = c_mo ? (c_yl ? 8'h00 : binc(tm[5])) : tm[5];
    nt[6] = c_yl ? ((tm[6] == 8'h99) ? 8'h00 : binc(tm[6])) : tm[6];
    nt[7] = c_h ? ((tm[7] >= 8'd6) ? 8'h00 : tm[7] + 8'd1) : tm[7];
    hit = 1'b1;
    for (int i = 0; i < 7; i++) hit = hit && (nt[i] == al[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_s1  <= 1'b0;
      running <= 1'b0;
      presc   <= '0;
    end else begin
      if (tick_32k) begin
        run_s1  <= ctrl_run;
        running <= run_s1;
      end
      if (!running) presc <= '0;
      else if (tick_32k) presc <= (presc == LAST) ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        tm[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
        sh[i] <= 8'h00;
      end
    end else begin
      if (sec_pulse) begin
        for (int i = 0; i < 8; i++) tm[i] <= nt[i];
      end else if (wr_time) begin
        tm[addr[2:0]] <= wdata & fmask(addr[2:0]);
      end
      if (wr_ctrl && wdata[6]) begin
        for (int i = 0; i < 8; i++) sh[i] <= tm[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) al[i] <= 8'h00;
      ctrl_run <= 1'b0;
      rdsel    <= 1'b0;
      int_en   <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (wr_alm) al[addr[2:0]] <= wdata & fmask(addr[2:0]);
      if (wr_ctrl) begin
        ctrl_run <= wdata[0];
        rdsel    <= wdata[7];
      end
      if (wr_en && addr == A_IEN) int_en <= wdata[7];
      if (sec_pulse && hit) pend <= 1'b1;
      else if (clr_req) pend <= 1'b0;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr < A_ALM) rdata = rdsel ? sh[addr[2:0]] : tm[addr[2:0]];
    else if (addr <= A_ALMH) rdata = al[addr[2:0]];
    else if (addr == A_CTRL) rdata = {rdsel, 6'b0, ctrl_run};
    else if (addr == A_STAT) rdata = {3'b0, pend, 3'b0, running};
    else if (addr == A_IEN) rdata = {int_en, 7'b0};
  end

  AST_RUN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_32k |=> $stable(running)); // R3
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> $stable(tm[0])); // R4
  AST_LOAD_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_en && addr == A_WDAY && !sec_pulse) |=> $stable(tm[7])); // R5
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && wdata[6]) |=> $stable(sh[0])); // R9
  AST_PEND_AT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(sec_pulse)); // R10
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_req) |=> pend); // R11
endmodule

// File: tb/bcd_rtc_tb_top.sv
module bcd_rtc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_rtc #(.TICKS_PER_SEC(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tk();
    @(negedge clk);
    tick_32k = 1'b1;
    @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic tk_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_32k = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    tick_32k = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_run(input logic [7:0] c);
    wr(5'd15, c);
    tk();
    tk();
  endtask

  task automatic second();
    repeat (4) tk();
  endtask

  task automatic load(input logic [63:0] t);
    set_run(8'h00);
    for (int i = 0; i < 8; i++) wr(5'(i), t[i*8 +: 8]);
    set_run(8'h01);
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      rd(5'(i), b);
      t[i*8 +: 8] = b;
    end
  endtask

  task automatic roll(input string tag, input logic [63:0] t, input logic [63:0] exp);
    logic [63:0] got;
    load(t);
    second();
    rd_time(got);
    chk(tag, got, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic [63:0] t;
    rd_time(t);
    chk("R1 time after reset", t, 64'h00_00_00_01_01_00_00_00);
    for (int i = 8; i < 18; i++) begin
      rd(5'(i), v);
      chk("R1 register after reset", {56'h0, v}, 64'h0);
    end
    rd(5'd20, v);
    chk("R2 unmapped index", {56'h0, v}, 64'h0);
    chk("R1 irq after reset", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(5'd2, 8'hFF); rd(5'd2, v); chk("R2 hours mask", {56'h0, v}, 64'h3F);
    wr(5'd7, 8'hFF); rd(5'd7, v); chk("R2 weekday mask", {56'h0, v}, 64'h07);
    wr(5'd8, 8'hFF); rd(5'd8, v); chk("R2 alarm seconds mask", {56'h0, v}, 64'h7F);
    wr(5'd17, 8'hFF); rd(5'd17, v); chk("R2 int enable mask", {56'h0, v}, 64'h80);
    wr(5'd17, 8'h00);
  endtask

  task automatic t_run();
    logic [7:0] v;
    load(64'h00_20_25_01_10_09_00_00);
    set_run(8'h00);
    wr(5'd15, 8'h01);
    rd(5'd16, v); chk("R3 status before ticks", {56'h0, v}, 64'h00);
    tk();
    rd(5'd16, v); chk("R3 status after one tick", {56'h0, v}, 64'h00);
    tk();
    rd(5'd16, v); chk("R3 status after two ticks", {56'h0, v}, 64'h01);
    repeat (3) tk();
    rd(5'd0, v); chk("R4 no advance before full second", {56'h0, v}, 64'h00);
    tk();
    rd(5'd0, v); chk("R4 one second", {56'h0, v}, 64'h01);
    second();
    rd(5'd0, v); chk("R4 second second", {56'h0, v}, 64'h02);
  endtask

  task automatic t_load_guard();
    logic [7:0] v;
    wr(5'd0, 8'h45);
    rd(5'd0, v); chk("R5 load while running", {56'h0, v}, 64'h02);
    wr(5'd15, 8'h00);
    wr(5'd0, 8'h45);
    rd(5'd0, v); chk("R5 load before stop confirmed", {56'h0, v}, 64'h02);
    tk(); tk();
    wr(5'd0, 8'h45);
    rd(5'd0, v); chk("R5 load after stop", {56'h0, v}, 64'h45);
  endtask

  task automatic t_calendar();
    roll("R6 R8 midnight", 64'h06_20_24_03_15_23_59_59, 64'h00_20_24_03_16_00_00_00);
    roll("R6 hour carry", 64'h02_20_24_03_15_10_59_59, 64'h02_20_24_03_15_11_00_00);
    roll("R7 leap february 28", 64'h03_20_24_02_28_23_59_59, 64'h04_20_24_02_29_00_00_00);
    roll("R7 leap february 29", 64'h04_20_24_02_29_23_59_59, 64'h05_20_24_03_01_00_00_00);
    roll("R7 common february", 64'h01_20_23_02_28_23_59_59, 64'h02_20_23_03_01_00_00_00);
    roll("R7 year 2000 leap", 64'h01_20_00_02_28_23_59_59, 64'h02_20_00_02_29_00_00_00);
    roll("R7 year 2100 common", 64'h01_21_00_02_28_23_59_59, 64'h02_21_00_03_01_00_00_00);
    roll("R7 thirty day month", 64'h05_20_25_04_30_23_59_59, 64'h06_20_25_05_01_00_00_00);
    roll("R7 january end", 64'h05_20_25_01_31_23_59_59, 64'h06_20_25_02_01_00_00_00);
    roll("R7 R8 century carry", 64'h03_20_99_12_31_23_59_59, 64'h04_21_00_01_01_00_00_00);
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    load(64'h00_20_25_06_05_08_00_10);
    wr(5'd15, 8'h41);
    rd(5'd15, v); chk("R9 capture bit reads zero", {56'h0, v}, 64'h01);
    wr(5'd15, 8'h81);
    second();
    rd(5'd0, v); chk("R9 snapshot seconds", {56'h0, v}, 64'h10);
    rd(5'd2, v); chk("R9 snapshot hours", {56'h0, v}, 64'h08);
    wr(5'd15, 8'h01);
    rd(5'd0, v); chk("R9 live seconds", {56'h0, v}, 64'h11);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr(5'd8, 8'h30); wr(5'd9, 8'h20); wr(5'd10, 8'h10); wr(5'd11, 8'h05);
    wr(5'd12, 8'h06); wr(5'd13, 8'h25); wr(5'd14, 8'h20);
    wr(5'd17, 8'h80);
    load(64'h00_20_25_06_05_10_20_30);
    rd(5'd16, v); chk("R10 load of matching time", {56'h0, v}, 64'h01);
    load(64'h00_20_25_06_05_10_20_29);
    second();
    rd(5'd16, v); chk("R10 match sets pending", {56'h0, v}, 64'h11);
    chk("R12 irq with enable", {63'h0, irq}, 64'h1);
    wr(5'd16, 8'h00);
    rd(5'd16, v); chk("R11 write zero keeps pending", {56'h0, v}, 64'h11);
    wr(5'd16, 8'h10);
    rd(5'd16, v); chk("R11 write one clears", {56'h0, v}, 64'h01);
    chk("R12 irq after clear", {63'h0, irq}, 64'h0);
    second();
    rd(5'd16, v); chk("R10 no match next second", {56'h0, v}, 64'h01);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(5'd17, 8'h00);
    load(64'h00_20_25_06_05_10_20_29);
    second();
    rd(5'd16, v); chk("R10 pending with enable off", {56'h0, v}, 64'h11);
    chk("R12 irq masked", {63'h0, irq}, 64'h0);
    load(64'h00_20_25_06_05_10_20_29);
    repeat (3) tk();
    tk_wr(5'd16, 8'h10);
    rd(5'd16, v); chk("R11 set wins over clear", {56'h0, v}, 64'h11);
    wr(5'd16, 8'h10);
    rd(5'd16, v); chk("R11 clear afterwards", {56'h0, v}, 64'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_run();
    t_load_guard();
    t_calendar();
    t_snapshot();
    t_alarm();
    t_collision();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule